// File: doc/BRIEF.md
# Lookahead Synchronous RAM

This block puts a single-clock block RAM behind a processor-style address register so that the datapath sees read data in the same cycle it would have seen it from an asynchronous RAM. The datapath computes the address it wants for the next cycle and normally loads it into an address register. Here that pre-register value also drives the RAM read port. The read therefore starts one cycle early, and its registered result lines up with the cycle in which the address register holds the same address.

The RAM reads on every clock edge, because the decode that would qualify a read settles too late to gate it. A write is signalled in the cycle after its address was computed, and it lands at the registered current address. Two variants are selected by parameter:

- **Single-port.** Reads and writes share one RAM address. The address register stops loading while a write is in progress, so the port stays on the address that was latched before the write. A second parameter chooses whether the read output shows the new word or the old contents during a write.
- **Dual-port.** One port only reads at the lookahead address and the other only writes at the current address, so the address register keeps advancing while a write completes.

Top module: `lookahead_ram`

## Requirements
- R1: While `rst` is high, `cur_addr` is forced to 0. It reads 0 at the first rising edge after `rst` falls, until a load changes it. The memory contents are not cleared, and `rdata` is undefined until the first edge after reset.
- R2: The lookahead address is `next_addr` when the register loads this cycle, and `cur_addr` otherwise. In a cycle with no write, `rdata` after the rising edge equals the stored word at that lookahead address.
- R3: In a cycle with no write, `cur_addr` takes `next_addr` at the rising edge when `addr_load` is 1, and keeps its value when `addr_load` is 0.
- R4: When `we` is 1, `wdata` is stored at the value `cur_addr` held before the edge, never at `next_addr`.
- R5: In the single-port variant (`DUAL_PORT`=0), `cur_addr` holds its value across any cycle with `we`=1, even when `addr_load` is 1.
- R6: In the single-port variant, `rdata` after a write cycle is the written word when `WRITE_FIRST`=1, and the previous contents of that location when `WRITE_FIRST`=0.
- R7: In the dual-port variant (`DUAL_PORT`=1), a write cycle still loads the address register. `rdata` after the edge is the word at the lookahead address, read at the same time as the write to the old `cur_addr`.
- R8: In the dual-port variant, suppose a write cycle's lookahead address equals `cur_addr`. Then `rdata` is `wdata` when `WRITE_FIRST`=1, and the old contents when `WRITE_FIRST`=0.
- R9: Elaboration rejects the following parameter settings: `DEPTH` below 2 or not a power of two, `DATA_W` below 1, and `WRITE_FIRST` or `DUAL_PORT` outside 0..1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the register and the RAM |
| rst | input | 1 | Synchronous active-high reset of the address register |
| next_addr | input | $clog2(DEPTH) | Address computed by the datapath for the next access |
| addr_load | input | 1 | Load `next_addr` into the address register |
| we | input | 1 | Write `wdata` at the current address this cycle |
| wdata | input | DATA_W | Word to store |
| rdata | output | DATA_W | Registered read word for the current address |
| cur_addr | output | $clog2(DEPTH) | Address register contents |

## Verification
Suppose the lookahead address fed the RAM from the register output instead of its input. Then `rdata` would lag `cur_addr` by one load, and a shadow-memory comparison would show a mismatch in the first cycle after any load to a new address. Suppose the hold during single-port writes were missing. Then `cur_addr` would jump at the end of that write cycle, and the stored word would be found at the wrong location on the very next read of either address. A wrong write-first choice, or a missing collision bypass, shows on `rdata` in the cycle right after the write.

// File: rtl/lar_pkg.sv
package lar_pkg;

   // Legal-parameter helpers, evaluated at elaboration.
   function automatic bit lar_is_pow2(input int unsigned n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

   function automatic bit lar_is_flag(input int unsigned v);
      return v <= 1;
   endfunction

   // Variant selector, derived from the DUAL_PORT parameter.
   typedef enum logic {
      LAR_SHARED_PORT = 1'b0,
      LAR_SPLIT_PORT  = 1'b1
   } lar_port_mode_e;

endpackage

// File: rtl/lar_addr_reg.sv
// Address register with lookahead tap: la_addr is the register's D input.
module lar_addr_reg #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] next_addr,
   input  logic              load,
   input  logic              hold,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] la_addr
);

   logic              take_next;
   logic [ADDR_W-1:0] cur_q;

   assign take_next = load & ~hold;
   assign la_addr   = take_next ? next_addr : cur_q;
   assign cur_addr  = cur_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_q <= '0;
      end else begin
         cur_q <= la_addr;
      end
   end

   // R1: the register is zero on the first edge after reset is released
   a_r1_reset_zero: assert property (@(posedge clk)
      $fell(rst) |-> cur_addr == '0);

   // R3: a load without hold captures the next address
   a_r3_load_next: assert property (@(posedge clk) disable iff (rst)
      (load && !hold) |=> cur_addr == $past(next_addr));

   // R3: no load, no change
   a_r3_idle_stable: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(cur_addr));

   // R5: hold wins over load
   a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
      hold |=> $stable(cur_addr));

endmodule

// File: rtl/lar_mem_shared.sv
// Single-port inferred RAM: one address, read every cycle, optional write-first.
module lar_mem_shared #(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 1024,
   parameter int WRITE_FIRST = 1,
   localparam int ADDR_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (WRITE_FIRST != 0) begin : g_wf
         always_ff @(posedge clk) begin
            if (we) begin
               mem[addr] <= wdata;
               rdata     <= wdata;
            end else begin
               rdata     <= mem[addr];
            end
         end

         // R6: write-first returns the new word
         a_r6_write_first: assert property (@(posedge clk) disable iff (rst)
            we |=> rdata == $past(wdata));
      end else begin : g_rf
         always_ff @(posedge clk) begin
            if (we) begin
               mem[addr] <= wdata;
            end
            rdata <= mem[addr];
         end

         // R6: read-first leaves the old word visible while the same address stays
         a_r6_read_first: assert property (@(posedge clk) disable iff (rst)
            (we && $past(we) && $stable(addr)) |=> rdata == $past(wdata, 2));
      end
   endgenerate

endmodule

// File: rtl/lar_mem_split.sv
// Dual-port inferred RAM: one read-only port and one write-only port.
module lar_mem_split #(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 1024,
   parameter int WRITE_FIRST = 1,
   localparam int ADDR_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic              clash;

   assign clash = we & (rd_addr == wr_addr);

   always_ff @(posedge clk) begin
      if (we) begin
         mem[wr_addr] <= wdata;
      end
   end

   generate
      if (WRITE_FIRST != 0) begin : g_wf
         always_ff @(posedge clk) begin
            if (clash) begin
               rdata <= wdata;
            end else begin
               rdata <= mem[rd_addr];
            end
         end

         // R8: a colliding read sees the incoming word
         a_r8_clash_new: assert property (@(posedge clk) disable iff (rst)
            (we && rd_addr == wr_addr) |=> rdata == $past(wdata));
      end else begin : g_rf
         always_ff @(posedge clk) begin
            rdata <= mem[rd_addr];
         end
      end
   endgenerate

endmodule

// File: rtl/lookahead_ram.sv
module lookahead_ram #(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 1024,
   parameter int WRITE_FIRST = 1,
   parameter int DUAL_PORT   = 0,
   localparam int ADDR_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] next_addr,
   input  logic              addr_load,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] cur_addr
);
   import lar_pkg::*;

   localparam lar_port_mode_e MODE = (DUAL_PORT != 0) ? LAR_SPLIT_PORT : LAR_SHARED_PORT;

   // R9: parameter legality
   generate
      if (!lar_is_pow2(DEPTH)) begin : g_bad_depth
         $error("lookahead_ram: DEPTH must be a power of two and at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("lookahead_ram: DATA_W must be positive");
      end
      if (!lar_is_flag(WRITE_FIRST) || !lar_is_flag(DUAL_PORT)) begin : g_bad_flag
         $error("lookahead_ram: WRITE_FIRST and DUAL_PORT take 0 or 1");
      end
   endgenerate

   logic [ADDR_W-1:0] la_addr;
   logic              hold;

   // Only the shared port must keep the address during a write.
   assign hold = (MODE == LAR_SHARED_PORT) ? we : 1'b0;

   lar_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
      .clk      (clk),
      .rst      (rst),
      .next_addr(next_addr),
      .load     (addr_load),
      .hold     (hold),
      .cur_addr (cur_addr),
      .la_addr  (la_addr)
   );

   generate
      if (MODE == LAR_SHARED_PORT) begin : g_shared
         lar_mem_shared #(
            .DATA_W(DATA_W), .DEPTH(DEPTH), .WRITE_FIRST(WRITE_FIRST)
         ) u_mem (
            .clk  (clk),
            .rst  (rst),
            .addr (la_addr),
            .we   (we),
            .wdata(wdata),
            .rdata(rdata)
         );

         // R5: a write never moves the shared address
         a_r5_write_holds: assert property (@(posedge clk) disable iff (rst)
            (we && addr_load) |=> cur_addr == $past(cur_addr));
      end else begin : g_split
         lar_mem_split #(
            .DATA_W(DATA_W), .DEPTH(DEPTH), .WRITE_FIRST(WRITE_FIRST)
         ) u_mem (
            .clk    (clk),
            .rst    (rst),
            .rd_addr(la_addr),
            .wr_addr(cur_addr),
            .we     (we),
            .wdata  (wdata),
            .rdata  (rdata)
         );

         // R7: the register keeps advancing during writes
         a_r7_write_advances: assert property (@(posedge clk) disable iff (rst)
            (we && addr_load) |=> cur_addr == $past(next_addr));
      end
   endgenerate

endmodule

// File: tb/lookahead_ram_tb_top.sv
module lookahead_ram_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int DEPTH = 16;
   localparam int AW = 4;
   localparam int NV = 4; // 0: shared/wf 1: shared/rf 2: split/wf 3: split/rf

   typedef struct packed {
      logic          ld;
      logic [AW-1:0] na;
      logic          we;
      logic [DW-1:0] wd;
   } vec_t;

   // Mixed stimulus; expected values come from the shadow model.
   localparam int NVEC = 20;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 4'd3,  1'b0, 8'h00},
      '{1'b1, 4'd9,  1'b0, 8'h00},
      '{1'b0, 4'd1,  1'b0, 8'h00},
      '{1'b0, 4'd2,  1'b1, 8'hA5},
      '{1'b1, 4'd4,  1'b1, 8'h5A},
      '{1'b1, 4'd4,  1'b0, 8'h00},
      '{1'b1, 4'd9,  1'b0, 8'h00},
      '{1'b1, 4'd15, 1'b0, 8'h00},
      '{1'b0, 4'd0,  1'b1, 8'hC3},
      '{1'b1, 4'd15, 1'b1, 8'h3C},
      '{1'b1, 4'd0,  1'b0, 8'h00},
      '{1'b1, 4'd15, 1'b0, 8'h00},
      '{1'b1, 4'd7,  1'b1, 8'h77},
      '{1'b1, 4'd7,  1'b0, 8'h00},
      '{1'b1, 4'd8,  1'b0, 8'h00},
      '{1'b0, 4'd8,  1'b1, 8'h88},
      '{1'b1, 4'd7,  1'b0, 8'h00},
      '{1'b1, 4'd8,  1'b0, 8'h00},
      '{1'b1, 4'd5,  1'b0, 8'h00},
      '{1'b1, 4'd5,  1'b1, 8'hE1}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] next_addr = '0;
   logic          addr_load = 1'b0;
   logic          we = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rd_w  [NV];
   logic [AW-1:0] cur_w [NV];

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [DW-1:0] shadow [NV][DEPTH];
   bit            known  [DEPTH];
   logic [AW-1:0] cur_m  [NV];

   always #(CLK_PERIOD/2) clk = ~clk;

   generate
      for (genvar v = 0; v < NV; v++) begin : g_v
         lookahead_ram #(
            .DATA_W(DW), .DEPTH(DEPTH),
            .WRITE_FIRST((v % 2) == 0 ? 1 : 0),
            .DUAL_PORT(v >= 2 ? 1 : 0)
         ) dut_i (
            .clk      (clk),
            .rst      (rst),
            .next_addr(next_addr),
            .addr_load(addr_load),
            .we       (we),
            .wdata    (wdata),
            .rdata    (rd_w[v]),
            .cur_addr (cur_w[v])
         );
      end
   endgenerate

   task automatic check(input bit ok, input string tag, input int v,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s variant=%0d actual=%0h expected=%0h", tag, v, act, exp);
      end
   endtask

   // One clock of stimulus. Inputs change after a falling edge; outputs are
   // sampled 1 time unit after the rising edge.
   task automatic step(input logic ld, input logic [AW-1:0] na, input logic w,
                       input logic [DW-1:0] wd, input string rtag);
      logic [DW-1:0] exp_rd [NV];
      bit            exp_ok [NV];
      logic [AW-1:0] exp_cur [NV];
      addr_load = ld; next_addr = na; we = w; wdata = wd;
      for (int v = 0; v < NV; v++) begin
         bit sp = (v < 2);
         bit wf = ((v % 2) == 0);
         logic [AW-1:0] la = (ld && !(w && sp)) ? na : cur_m[v];
         if (w && wf && la == cur_m[v]) begin
            exp_rd[v] = wd; exp_ok[v] = 1'b1;
         end else begin
            exp_rd[v] = shadow[v][la]; exp_ok[v] = known[la];
         end
         exp_cur[v] = la;
      end
      @(posedge clk);
      #1;
      for (int v = 0; v < NV; v++) begin
         bit sp = (v < 2);
         string ctag;
         string dtag;
         if (w) begin
            shadow[v][cur_m[v]] = wd;
         end
         ctag = (w && ld) ? (sp ? "R5" : "R7") : "R3";
         dtag = w ? (sp ? "R6" : "R8") : rtag;
         cur_m[v] = exp_cur[v];
         check(cur_w[v] === exp_cur[v], ctag, v, int'(cur_w[v]), int'(exp_cur[v]));
         if (exp_ok[v]) begin
            check(rd_w[v] === exp_rd[v], dtag, v, int'(rd_w[v]), int'(exp_rd[v]));
         end
      end
      if (w) begin
         for (int v = 0; v < NV; v++) known[cur_m[v]] = 1'b1;
      end
      @(negedge clk);
   endtask

   initial begin
      for (int a = 0; a < DEPTH; a++) known[a] = 1'b0;
      for (int v = 0; v < NV; v++) cur_m[v] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      #1;
      for (int v = 0; v < NV; v++)
         check(cur_w[v] === '0, "R1", v, int'(cur_w[v]), 0);
      @(negedge clk);

      // Fill every location: load the address, then write at it (R4).
      for (int a = 0; a < DEPTH; a++) begin
         step(1'b1, AW'(a), 1'b0, '0, "R2");
         step(1'b0, AW'(a), 1'b1, DW'(a * 7 + 3), "R4");
      end
      // Read back the fill with the lookahead path (R2).
      for (int a = DEPTH - 1; a >= 0; a--) begin
         step(1'b1, AW'(a), 1'b0, '0, "R2");
      end

      // Table walk.
      foreach (VEC[i]) begin
         step(VEC[i].ld, VEC[i].na, VEC[i].we, VEC[i].wd, "R2");
      end

      // R4: the write goes to the held address, not next_addr.
      step(1'b1, 4'd10, 1'b0, '0, "R2");
      step(1'b1, 4'd11, 1'b1, 8'hB4, "R4");
      step(1'b1, 4'd11, 1'b0, '0, "R4");
      step(1'b1, 4'd10, 1'b0, '0, "R4");

      // R8: split-port write with the lookahead on the written location.
      step(1'b0, 4'd0, 1'b1, 8'h6D, "R8");
      step(1'b0, 4'd0, 1'b0, '0, "R2");

      // R1: reset mid-run clears the address but not the array.
      @(negedge clk);
      rst = 1'b1; addr_load = 1'b0; we = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int v = 0; v < NV; v++) cur_m[v] = '0;
      @(posedge clk);
      #1;
      for (int v = 0; v < NV; v++)
         check(cur_w[v] === '0, "R1", v, int'(cur_w[v]), 0);
      @(negedge clk);
      step(1'b0, 4'd0, 1'b0, '0, "R1");
      step(1'b1, 4'd10, 1'b0, '0, "R1");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule